// File: doc/BRIEF.md
# Bidirectional Counting Pixel Array with Neighbour Transfer

Each pixel of a digital readout array integrates a photocurrent by counting pulses from a pulse-frequency-modulated front end. Every pulse stands for one fixed reference charge packet and moves the pixel's 16-bit register by one step. Counting can go up or down, so a frame can add scene signal and later subtract a background. The register wraps around on overflow instead of saturating. This lets a pixel keep counting under a large background pedestal without stalling.

The pixels form a parameterized grid. On one shift strobe, every pixel loads the register of one chosen neighbour in the same clock edge. Pixels on the array edge that lack that neighbour load a preload word instead. This supports time delay integration, image stabilization and shift-and-integrate spatial filters. In split mode each register works as two independent 8-bit banks, each with its own count direction. Each pixel also holds a 12-bit trim word that drives its gain-correction DAC. The analog integrator, comparator and DAC are outside this block, and the count pulse arrives as a one-cycle digital strobe.

Top module: `pix_array`

## Requirements
- R1: When `en_i` is high and a pixel's `cnt_pulse_i` bit is high, that pixel's register moves by one: up when `dir_lo_i` is 1, down when it is 0 (non-split mode).
- R2: A pixel whose pulse bit is low, or any pixel while `en_i` is low, keeps its register value when no shift and no clear is requested.
- R3: In non-split mode the register wraps modulo 2^16: 0xFFFF counted up gives 0x0000, and 0x0000 counted down gives 0xFFFF. A carry crosses from bit 7 into bit 8.
- R4: On `shift_i`, every pixel loads at once the register of the neighbour selected by `shift_dir_i`: 0 from the pixel in the row above (row-1), 1 from the row below (row+1), 2 from the column to the left (col-1), 3 from the column to the right (col+1). Pixel index is row*COLS+col.
- R5: An edge pixel whose selected neighbour does not exist loads `preload_i`.
- R6: A shift and a count pulse in the same cycle are applied shift first. The pixel ends at the loaded value plus or minus one, so no pulse is lost.
- R7: With `split_i` high, bits 7:0 count by `dir_lo_i` and bits 15:8 count by `dir_hi_i`. Each bank moves by one on every qualified pulse.
- R8: In split mode each bank wraps at 8 bits with no carry or borrow into the other bank.
- R9: `clr_i` sets the register to zero in the next cycle and takes priority over shift and count.
- R10: A cycle with `trim_we_i` high writes `trim_data_i` into the trim word of the pixel `trim_addr_i`. All other trim words stay unchanged.
- R11: After reset, all registers read 0 and all trim words read 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all registers |
| en_i | input | 1 | Count enable |
| cnt_pulse_i | input | ROWS*COLS | Count pulse, one bit per pixel |
| dir_lo_i | input | 1 | Direction of the full counter or the low bank, 1 = up |
| dir_hi_i | input | 1 | Direction of the high bank in split mode, 1 = up |
| split_i | input | 1 | Select two 8-bit banks |
| shift_i | input | 1 | Neighbour transfer strobe |
| shift_dir_i | input | 2 | Source neighbour code |
| preload_i | input | CNT_W | Value loaded at the array edge |
| trim_we_i | input | 1 | Trim word write strobe |
| trim_addr_i | input | clog2(ROWS*COLS) | Pixel selected for trim write |
| trim_data_i | input | TRIM_W | Trim word to write |
| value_o | output | ROWS*COLS*CNT_W | Registers, pixel p at bits p*CNT_W |
| trim_o | output | ROWS*COLS*TRIM_W | Trim words, pixel p at bits p*TRIM_W |

## Verification
A corrupted register shows on `value_o` one cycle after the fault. Every later shift then carries the error to the neighbour on the far side of the transfer, so after one sweep it reaches an edge pixel. A wrong neighbour selection or a bad edge preload shows up as a permuted or duplicated value after a single strobe. The bench loads distinct values into the grid so that such faults cannot hide. Carry leaking between banks in split mode appears in the opposite bank on the first pulse across a bank boundary. A wrong trim decode appears at once on a non-addressed pixel's `trim_o` slice.

// File: rtl/pix_pkg.sv
`timescale 1ns/1ps
package pix_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned TRIM_W = 12;

  typedef enum logic [1:0] {
    SH_FROM_UP    = 2'd0,
    SH_FROM_DOWN  = 2'd1,
    SH_FROM_LEFT  = 2'd2,
    SH_FROM_RIGHT = 2'd3
  } shift_dir_e;
endpackage

// File: rtl/pix_counter.sv
`timescale 1ns/1ps
module pix_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         dir_lo_i,
  input  logic         dir_hi_i,
  input  logic         split_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned HW = W / 2;
  localparam logic [W-1:0]  ONE  = 1;
  localparam logic [HW-1:0] HONE = 1;

  logic [W-1:0]  base, full, nxt;
  logic [HW-1:0] lo, hi;

  always_comb begin
    base = load_i ? load_val_i : q_o;   // shift first, then count
    full = dir_lo_i ? base + ONE : base - ONE;
    lo   = dir_lo_i ? base[HW-1:0] + HONE : base[HW-1:0] - HONE;
    hi   = dir_hi_i ? base[W-1:HW] + HONE : base[W-1:HW] - HONE;
    if (!step_i)      nxt = base;
    else if (split_i) nxt = {hi, lo};
    else              nxt = full;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else             q_o <= nxt;
  end

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> q_o == '0);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !step_i) |=> $stable(q_o));
  a_r1_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && step_i && !split_i && dir_lo_i) |=> q_o == $past(q_o) + ONE);
  a_r1_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && step_i && !split_i && !dir_lo_i) |=> q_o == $past(q_o) - ONE);
  a_r6_load_then_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_i && step_i && !split_i && dir_lo_i) |=> q_o == $past(load_val_i) + ONE);
  a_r7_hi_bank_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && step_i && split_i && dir_hi_i)
      |=> q_o[W-1:HW] == $past(q_o[W-1:HW]) + HONE);
  a_r8_lo_bank_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && step_i && split_i && !dir_lo_i)
      |=> q_o[HW-1:0] == $past(q_o[HW-1:0]) - HONE);
endmodule

// File: rtl/pix_trim.sv
`timescale 1ns/1ps
module pix_trim #(
  parameter int unsigned       W   = 12,
  parameter logic [W-1:0]      RST = 12'h800
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] trim_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   trim_o <= RST;
    else if (we_i) trim_o <= data_i;
  end

  a_r10_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> trim_o == $past(data_i));
  a_r10_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(trim_o));
endmodule

// File: rtl/pix_cell.sv
`timescale 1ns/1ps
module pix_cell
  import pix_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned TW = TRIM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          pulse_i,
  input  logic          dir_lo_i,
  input  logic          dir_hi_i,
  input  logic          split_i,
  input  logic          shift_i,
  input  logic [1:0]    shift_dir_i,
  input  logic [CW-1:0] nb_up_i,
  input  logic [CW-1:0] nb_down_i,
  input  logic [CW-1:0] nb_left_i,
  input  logic [CW-1:0] nb_right_i,
  input  logic          trim_we_i,
  input  logic [TW-1:0] trim_data_i,
  output logic [CW-1:0] value_o,
  output logic [TW-1:0] trim_o
);
  logic [CW-1:0] sel;
  logic          step;

  always_comb begin
    unique case (shift_dir_e'(shift_dir_i))
      SH_FROM_UP:    sel = nb_up_i;
      SH_FROM_DOWN:  sel = nb_down_i;
      SH_FROM_LEFT:  sel = nb_left_i;
      default:       sel = nb_right_i;
    endcase
  end

  assign step = en_i & pulse_i;

  pix_counter #(.W(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .load_i     (shift_i),
    .load_val_i (sel),
    .step_i     (step),
    .dir_lo_i   (dir_lo_i),
    .dir_hi_i   (dir_hi_i),
    .split_i    (split_i),
    .q_o        (value_o)
  );

  pix_trim #(.W(TW)) u_trim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (trim_we_i),
    .data_i (trim_data_i),
    .trim_o (trim_o)
  );

  a_r4_shift_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clr_i && !step) |=> value_o == $past(sel));
endmodule

// File: rtl/pix_array.sv
`timescale 1ns/1ps
module pix_array
  import pix_pkg::*;
#(
  parameter int unsigned ROWS = 2,
  parameter int unsigned COLS = 2,
  localparam int unsigned N   = ROWS * COLS,
  localparam int unsigned AW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [N-1:0]       cnt_pulse_i,
  input  logic               dir_lo_i,
  input  logic               dir_hi_i,
  input  logic               split_i,
  input  logic               shift_i,
  input  logic [1:0]         shift_dir_i,
  input  logic [CNT_W-1:0]   preload_i,
  input  logic               trim_we_i,
  input  logic [AW-1:0]      trim_addr_i,
  input  logic [TRIM_W-1:0]  trim_data_i,
  output logic [N*CNT_W-1:0]  value_o,
  output logic [N*TRIM_W-1:0] trim_o
);
  logic [CNT_W-1:0] val [N];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned P = r * COLS + c;
      logic [CNT_W-1:0] up_w, dn_w, lf_w, rt_w;
      logic             we_w;

      if (r == 0)        begin : g_top  assign up_w = preload_i;          end
      else               begin : g_itop assign up_w = val[P-COLS];        end
      if (r == ROWS - 1) begin : g_bot  assign dn_w = preload_i;          end
      else               begin : g_ibot assign dn_w = val[P+COLS];        end
      if (c == 0)        begin : g_lft  assign lf_w = preload_i;          end
      else               begin : g_ilft assign lf_w = val[P-1];           end
      if (c == COLS - 1) begin : g_rgt  assign rt_w = preload_i;          end
      else               begin : g_irgt assign rt_w = val[P+1];           end

      assign we_w = trim_we_i && (trim_addr_i == AW'(P));

      pix_cell u_cell (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (clr_i),
        .en_i        (en_i),
        .pulse_i     (cnt_pulse_i[P]),
        .dir_lo_i    (dir_lo_i),
        .dir_hi_i    (dir_hi_i),
        .split_i     (split_i),
        .shift_i     (shift_i),
        .shift_dir_i (shift_dir_i),
        .nb_up_i     (up_w),
        .nb_down_i   (dn_w),
        .nb_left_i   (lf_w),
        .nb_right_i  (rt_w),
        .trim_we_i   (we_w),
        .trim_data_i (trim_data_i),
        .value_o     (val[P]),
        .trim_o      (trim_o[P*TRIM_W +: TRIM_W])
      );

      assign value_o[P*CNT_W +: CNT_W] = val[P];
    end
  end

  a_r5_edge_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clr_i && !en_i && shift_dir_i == 2'd2)
      |=> value_o[CNT_W-1:0] == $past(preload_i));
  a_r10_onehot_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trim_we_i) |=> $stable(trim_o));
endmodule

// File: tb/pix_array_test.sv
`timescale 1ns/1ps
module pix_array_test;
  localparam int ROWS = 2, COLS = 2, N = 4;

  logic clk = 0, rst_ni = 0;
  logic clr, en, dlo, dhi, split, shift, twe;
  logic [N-1:0] pulse;
  logic [1:0] sdir;
  logic [15:0] pre;
  logic [1:0] taddr;
  logic [11:0] tdata;
  logic [N*16-1:0] value;
  logic [N*12-1:0] trim;

  int checks = 0, errors = 0;
  logic [15:0] exp_v [N];
  logic [11:0] exp_t [N];

  always #5 clk = ~clk;

  pix_array #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .en_i(en), .cnt_pulse_i(pulse),
    .dir_lo_i(dlo), .dir_hi_i(dhi), .split_i(split), .shift_i(shift),
    .shift_dir_i(sdir), .preload_i(pre), .trim_we_i(twe), .trim_addr_i(taddr),
    .trim_data_i(tdata), .value_o(value), .trim_o(trim));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int p = 0; p < N; p++) begin
      chk(req, 32'(value[p*16 +: 16]), 32'(exp_v[p]));
      chk(req, 32'(trim[p*12 +: 12]), 32'(exp_t[p]));
    end
  endtask

  function automatic logic [15:0] neighbour(int p, logic [1:0] d, logic [15:0] pv);
    int r = p / COLS, c = p % COLS;
    case (d)
      2'd0: return (r == 0)        ? pv : exp_v[p-COLS];
      2'd1: return (r == ROWS - 1) ? pv : exp_v[p+COLS];
      2'd2: return (c == 0)        ? pv : exp_v[p-1];
      default: return (c == COLS - 1) ? pv : exp_v[p+1];
    endcase
  endfunction

  // one cycle of stimulus, model update, check after the edge
  task automatic cyc(string req, logic c_clr, logic c_en, logic [N-1:0] c_pulse,
                     logic c_dlo, logic c_dhi, logic c_split, logic c_shift,
                     logic [1:0] c_sdir, logic [15:0] c_pre);
    logic [15:0] nv [N];
    clr = c_clr; en = c_en; pulse = c_pulse; dlo = c_dlo; dhi = c_dhi;
    split = c_split; shift = c_shift; sdir = c_sdir; pre = c_pre;
    for (int p = 0; p < N; p++) begin
      logic [15:0] b;
      b = c_shift ? neighbour(p, c_sdir, c_pre) : exp_v[p];
      if (c_en && c_pulse[p]) begin
        if (c_split) begin
          b[7:0]  = c_dlo ? b[7:0] + 8'd1 : b[7:0] - 8'd1;
          b[15:8] = c_dhi ? b[15:8] + 8'd1 : b[15:8] - 8'd1;
        end else b = c_dlo ? b + 16'd1 : b - 16'd1;
      end
      nv[p] = c_clr ? 16'd0 : b;
    end
    @(negedge clk);
    for (int p = 0; p < N; p++) exp_v[p] = nv[p];
    clr = 0; en = 0; pulse = '0; shift = 0; split = 0;
    check_all(req);
  endtask

  task automatic t_reset;
    for (int p = 0; p < N; p++) begin exp_v[p] = 0; exp_t[p] = 12'h800; end
    check_all("R11");
  endtask

  task automatic t_count;
    cyc("R1", 0, 1, 4'b1111, 1, 0, 0, 0, 0, 0);
    cyc("R1", 0, 1, 4'b0011, 1, 0, 0, 0, 0, 0);
    cyc("R1", 0, 1, 4'b0001, 1, 0, 0, 0, 0, 0);
    chk("R1", 32'(value[15:0]), 32'd3);
    cyc("R1", 0, 1, 4'b0101, 0, 0, 0, 0, 0, 0);
    chk("R1", 32'(value[47:32]), 32'd0);
  endtask

  task automatic t_hold;
    cyc("R2", 0, 0, 4'b1111, 1, 1, 0, 0, 0, 0);
    cyc("R2", 0, 0, 4'b1111, 0, 0, 1, 0, 0, 0);
    cyc("R2", 0, 1, 4'b0000, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_shift;
    cyc("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, 2'd2, 16'hAAAA);
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 2'd2, 16'hBBBB);
    chk("R4", 32'(value[31:16]), 32'hAAAA);
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 2'd0, 16'hCCCC);
    chk("R4", 32'(value[47:32]), 32'hBBBB);
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 2'd1, 16'hDDDD);
    chk("R5", 32'(value[63:48]), 32'hDDDD);
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 2'd3, 16'hEEEE);
    chk("R4", 32'(value[15:0]), 32'hAAAA);
  endtask

  task automatic t_wrap;
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, 2'd2, 16'hFFFF);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, 2'd2, 16'hFFFF);
    cyc("R3", 0, 1, 4'b1111, 1, 0, 0, 0, 0, 0);
    chk("R3", 32'(value[15:0]), 32'h0000);
    cyc("R3", 0, 1, 4'b1111, 0, 0, 0, 0, 0, 0);
    chk("R3", 32'(value[15:0]), 32'hFFFF);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, 2'd0, 16'h00FF);
    cyc("R3", 0, 1, 4'b0001, 1, 0, 0, 0, 0, 0);
    chk("R3", 32'(value[15:0]), 32'h0100);
  endtask

  task automatic t_shift_count;
    cyc("R6", 0, 1, 4'b1111, 1, 0, 0, 1, 2'd2, 16'h1234);
    chk("R6", 32'(value[15:0]), 32'h1235);
    cyc("R6", 0, 1, 4'b0010, 0, 0, 0, 1, 2'd2, 16'h0000);
    chk("R6", 32'(value[31:16]), 32'h1234);
  endtask

  task automatic t_split;
    cyc("R7", 0, 0, 0, 0, 0, 0, 1, 2'd0, 16'h10FF);
    cyc("R7", 0, 0, 0, 0, 0, 0, 1, 2'd0, 16'h10FF);
    cyc("R8", 0, 1, 4'b1111, 1, 0, 1, 0, 0, 0);
    chk("R8", 32'(value[15:0]), 32'h0F00);
    cyc("R8", 0, 1, 4'b0101, 0, 1, 1, 0, 0, 0);
    chk("R8", 32'(value[15:0]), 32'h10FF);
    cyc("R7", 0, 1, 4'b1000, 1, 1, 1, 0, 0, 0);
    chk("R7", 32'(value[63:48]), 32'h1001);
  endtask

  task automatic t_clear;
    cyc("R9", 1, 1, 4'b1111, 1, 1, 0, 1, 2'd2, 16'h5555);
    chk("R9", 32'(value[31:16]), 32'h0);
  endtask

  task automatic t_trim;
    @(negedge clk);
    twe = 1; taddr = 2'd2; tdata = 12'h3A5;
    @(negedge clk);
    twe = 0; exp_t[2] = 12'h3A5;
    check_all("R10");
    twe = 1; taddr = 2'd0; tdata = 12'hFFF;
    @(negedge clk);
    twe = 0; exp_t[0] = 12'hFFF;
    check_all("R10");
  endtask

  initial begin
    clr = 0; en = 0; dlo = 0; dhi = 0; split = 0; shift = 0; twe = 0;
    pulse = '0; sdir = 0; pre = 0; taddr = 0; tdata = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_count();
    t_hold();
    t_shift();
    t_wrap();
    t_shift_count();
    t_split();
    t_clear();
    t_trim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule